// File: doc/BRIEF.md
# Dadda Tree Unsigned Multiplier

This block multiplies two unsigned 8-bit operands and returns the full 16-bit product. It has no clock or state. Every pairing of an `op_a` bit with an `op_b` bit becomes one partial-product bit. Bit `i` of `op_a` paired with bit `j` of `op_b` has weight 2^(i+j), so there are 64 such bits. They are grouped into columns by weight.

The columns are reduced in stages with full adders (3:2) and half adders (2:2). Each stage has a target height taken from the sequence 2, 3, 4, 6, 9, 13, where each value is `floor(3*previous/2)`. The first stage uses the largest value below the tallest column, which is 6 for this size. Later stages use 4, 3 and 2.

A column gets only as many adders as it needs to reach the stage target. Carries that arrive from the column below in the same stage count toward that height. When the last stage is done, no column holds more than two bits. A ripple-carry adder, built from the same full-adder cell, sums those two rows. Its final carry becomes product bit 15.

Top module: `dadda_mul`

## Requirements
- R1: For every pair of operands, `prod` equals the arithmetic product `op_a * op_b`.
- R2: If either operand is zero, `prod` is zero.
- R3: If one operand is 1, `prod` equals the other operand, zero-extended to 16 bits.
- R4: With both operands at 255, `prod` is 16'hFE01. Bit 15 is driven by the final carry, and the result never wraps.
- R5: Bit 0 of `prod` is always the AND of bit 0 of `op_a` and bit 0 of `op_b`.
- R6: If `op_b` is 2^k for k from 0 to 7, `prod` equals `op_a` shifted left by k bits.
- R7: Swapping the two operands does not change `prod`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| prod | output | 16 | Unsigned product |

## Verification
The hardest cases to reach are the long carry chains. These run through both the reduction stages and the final ripple adder, and only operand pairs whose upper bits are all set produce them. The top of the product range, near 255*255, is the main example. The bench therefore sweeps all 65,536 operand pairs, so every chain length and every column-height case in the tree is exercised. It then adds directed checks on the zero, identity, power-of-two and swapped-operand cases.

// File: rtl/dadda_mul.sv
module dadda_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  function automatic int seq_val(input int j);
    int d;
    d = 2;
    for (int k = 1; k < j; k++) d = (3 * d) / 2;
    return d;
  endfunction

  function automatic int stage_count(input int h);
    int n;
    n = 0;
    for (int k = 1; k < 32; k++) if (seq_val(k) < h) n = k;
    return n;
  endfunction

  localparam int NST = stage_count(W);

  logic [PW-1:0] row0, row1;
  logic [PW:0]   cy;

  always_comb begin
    logic [W-1:0] cur [PW];
    logic [W-1:0] nxt [PW];
    int hc [PW];
    int hn [PW];
    int k, t;
    for (int c = 0; c < PW; c++) begin
      cur[c] = '0;
      hc[c]  = 0;
    end
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++) begin
        cur[i+j][hc[i+j]] = op_a[i] & op_b[j];
        hc[i+j] = hc[i+j] + 1;
      end
    for (int s = 0; s < NST; s++) begin
      t = seq_val(NST - s);
      for (int c = 0; c < PW; c++) begin
        nxt[c] = '0;
        hn[c]  = 0;
      end
      for (int c = 0; c < PW; c++) begin
        k = 0;
        for (int u = 0; u < W; u++) begin
          if (hn[c] + hc[c] - k > t) begin
            if (hn[c] + hc[c] - k - t >= 2 && hc[c] - k >= 3) begin
              nxt[c][hn[c]] = cur[c][k] ^ cur[c][k+1] ^ cur[c][k+2];
              hn[c] = hn[c] + 1;
              if (c + 1 < PW) begin
                nxt[c+1][hn[c+1]] = (cur[c][k] & cur[c][k+1]) |
                                    (cur[c][k+2] & (cur[c][k] ^ cur[c][k+1]));
                hn[c+1] = hn[c+1] + 1;
              end
              k = k + 3;
            end else begin
              nxt[c][hn[c]] = cur[c][k] ^ cur[c][k+1];
              hn[c] = hn[c] + 1;
              if (c + 1 < PW) begin
                nxt[c+1][hn[c+1]] = cur[c][k] & cur[c][k+1];
                hn[c+1] = hn[c+1] + 1;
              end
              k = k + 2;
            end
          end
        end
        for (int u = 0; u < W; u++) begin
          if (k < hc[c]) begin
            nxt[c][hn[c]] = cur[c][k];
            hn[c] = hn[c] + 1;
            k = k + 1;
          end
        end
      end
      for (int c = 0; c < PW; c++) begin
        cur[c] = nxt[c];
        hc[c]  = hn[c];
      end
    end
    for (int c = 0; c < PW; c++) begin
      row0[c] = cur[c][0];
      row1[c] = cur[c][1];
    end
  end

  assign cy[0] = 1'b0;

  generate
    for (genvar g = 0; g < PW; g++) begin : g_rca
      assign prod[g]  = row0[g] ^ row1[g] ^ cy[g];
      assign cy[g+1]  = (row0[g] & row1[g]) | (cy[g] & (row0[g] ^ row1[g]));
    end
  endgenerate
endmodule

// File: rtl/dadda_mul_chk.sv
module dadda_mul_chk #(
  parameter int W = 8
) (
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [2*W-1:0] prod
);
  logic [2*W-1:0] ref_p;
  assign ref_p = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};

  always_comb begin
    AST_PRODUCT_MATCH: assert (prod == ref_p); // R1
    if (op_a == '0 || op_b == '0)
      AST_ZERO_OPERAND: assert (prod == '0); // R2
    if (op_b == W'(1))
      AST_UNIT_OPERAND: assert (prod == {{W{1'b0}}, op_a}); // R3
    if (op_a == '1 && op_b == '1)
      AST_NO_OVERFLOW: assert (prod == ref_p && prod[2*W-1]); // R4
    AST_LSB_AND: assert (prod[0] == (op_a[0] & op_b[0])); // R5
  end
endmodule

bind dadda_mul dadda_mul_chk #(.W(W)) i_dadda_mul_chk (.op_a(op_a), .op_b(op_b), .prod(prod));

// File: tb/test_dadda_mul.sv
module test_dadda_mul;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  a, b;
  logic [15:0] p;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dadda_mul i_dadda_mul (.op_a(a), .op_b(b), .prod(p));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    a = x;
    b = y;
    #1;
  endtask

  initial begin
    logic [15:0] keep;
    a = '0;
    b = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R2 idle", p, 16'd0);
    // R1 exhaustive sweep
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        apply(x[7:0], y[7:0]);
        check("R1", p, 16'(x * y));
      end
    for (int x = 0; x < 256; x += 17) begin
      apply(x[7:0], 8'd0); check("R2", p, 16'd0);
      apply(8'd0, x[7:0]); check("R2", p, 16'd0);
      apply(x[7:0], 8'd1); check("R3", p, {8'd0, x[7:0]});
      apply(8'd1, x[7:0]); check("R3", p, {8'd0, x[7:0]});
    end
    apply(8'd255, 8'd255); check("R4", p, 16'hFE01);
    apply(8'd255, 8'd128); check("R4", p, 16'd32640);
    for (int x = 0; x < 256; x += 5) begin
      apply(x[7:0], 8'hA5 ^ x[7:0]);
      check("R5", {15'd0, p[0]}, {15'd0, x[0] & ~x[0]});
    end
    for (int k = 0; k < 8; k++) begin
      apply(8'hB7, 8'(1 << k));
      check("R6", p, 16'(16'hB7 << k));
      apply(8'hFF, 8'(1 << k));
      check("R6", p, 16'(16'hFF << k));
    end
    for (int x = 3; x < 256; x += 29)
      for (int y = 250; y > 0; y -= 37) begin
        apply(x[7:0], y[7:0]);
        keep = p;
        apply(y[7:0], x[7:0]);
        check("R7", p, keep);
      end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
    end
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule